// File: doc/BRIEF.md
# Multi-Accept Output Contention Arbiter

This block decides, once per cell slot, which head-of-line cells of an N-port switch with buffering at both inputs and outputs may cross the fabric. Each input presents a single request: a valid flag and the index of the output it targets. Every output can take up to L cells in one slot, with 1 < L < N. When more than L inputs ask for the same output, the surplus requests are not granted. Those inputs keep their cells and ask again in a later slot. No cell is ever dropped.

Arbitration is combinational over the current request vector. The result is captured on the slot strobe and then held until the next strobe. Each output chooses among its requesters in round-robin order. Its rotating pointer moves to one past the last input it granted, so a persistent requester is served within a bounded number of slots. The outputs are one grant bit per input and, per output, the number of cells accepted in the slot. These drive the input buffer pop and the output buffer write enables.

Top module: `mao_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every grant bit and every accept count to zero, and sets every output's round-robin pointer to input 0.
- R2: The accept count of every output never exceeds L. Count field o occupies bits [o*CW +: CW] of `accept_cnt_o`, where CW = $clog2(L+1).
- R3: On each slot, every output accepts exactly min(number of valid requests addressed to it, L) cells. Requests beyond that number get no grant and must be presented again.
- R4: An input whose valid flag is low in the slot strobe cycle never receives a grant for that slot.
- R5: An input receives at most one grant per slot, and an output's accept count equals the number of granted inputs that addressed it. Destination field i occupies bits [i*DW +: DW] of `req_dest_i`, where DW = $clog2(N).
- R6: Grants and counts change only on a clock edge where `slot_i` is high. Request changes while `slot_i` is low have no effect on the outputs.
- R7: Each output scans the inputs in ascending index order, wrapping modulo N, starting at its pointer, and grants the first requesters it meets. After a slot in which it granted at least one input, its pointer becomes (last granted index + 1) mod N. Otherwise the pointer is unchanged.
- R8: Each output's pointer moves only on that output's own grants. Traffic to one output does not alter the selection order of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 1 | Slot strobe; the arbitration result is captured on edges where it is high |
| req_valid_i | input | N | Per-input head-of-line cell present |
| req_dest_i | input | N*DW | Per-input destination output index, field i at [i*DW +: DW] |
| grant_o | output | N | Per-input grant for the last slot |
| accept_cnt_o | output | N*CW | Per-output number of cells accepted in the last slot, field o at [o*CW +: CW] |

## Verification
The capacity cut-off and the pointer wrap-around can fall in the same slot. This happens when more than L inputs address one output whose pointer sits near the top of the index range, so the grant window crosses from input N-1 to input 0 while the extra requesters are refused. The bench forces this with directed slots in which all inputs address one output, repeated until the window wraps. It also steers random traffic into a few outputs so that both effects arise often together. Each slot's grant vector and counts are compared against a bench model that holds its own copy of the pointers and derives them from R3 and R7 alone.

// File: rtl/mao_pkg.sv
package mao_pkg;

    // Index reached by stepping 'off' positions from 'base' on a ring of n entries.
    function automatic int unsigned ring_step(input int unsigned base,
                                              input int unsigned off,
                                              input int unsigned n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/mao_out_sel.sv
// Round-robin selector for one output: picks up to L requesters starting at the pointer.
module mao_out_sel #(
    parameter int N  = 8,
    parameter int L  = 3,
    parameter int IW = $clog2(N),
    parameter int CW = $clog2(L + 1)
) (
    input  logic [N-1:0]  match_i,
    input  logic [IW-1:0] ptr_i,
    output logic [N-1:0]  sel_o,
    output logic [CW-1:0] cnt_o,
    output logic [IW-1:0] next_ptr_o
);
    import mao_pkg::*;

    always_comb begin
        logic [N-1:0]  sel;
        logic [CW-1:0] cnt;
        logic [IW-1:0] nptr;
        sel  = '0;
        cnt  = '0;
        nptr = ptr_i;
        for (int k = 0; k < N; k++) begin
            int unsigned idx;
            idx = ring_step(int'(ptr_i), k, N);
            if (match_i[idx] && (int'(cnt) < L)) begin
                sel[idx] = 1'b1;
                cnt      = cnt + 1'b1;
                nptr     = IW'(ring_step(idx, 1, N));
            end
        end
        sel_o      = sel;
        cnt_o      = cnt;
        next_ptr_o = nptr;
    end

    // R2: the selector never picks more than L inputs
    always_comb begin
        a_r2_sel_bound: assert ($countones(sel_o) <= L);
    end

    // R4: only requesting inputs are selected
    always_comb begin
        a_r4_sel_subset: assert ((sel_o & ~match_i) == '0);
    end
endmodule

// File: rtl/mao_rr_ptr.sv
// Rotating pointer of one output, advanced on a slot in which that output granted.
module mao_rr_ptr #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_i,
    input  logic          adv_i,
    input  logic [IW-1:0] next_i,
    output logic [IW-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (slot_i && adv_i) begin
            ptr_o <= next_i;
        end
    end

    // R7: the pointer stays put unless this output granted in a slot
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(slot_i && adv_i) |=> $stable(ptr_o));

    // R1: pointer cleared by reset
    a_r1_ptr_reset: assert property (@(posedge clk)
        rst |=> (ptr_o == '0));
endmodule

// File: rtl/mao_arbiter.sv
// Per-slot arbiter: every output accepts up to L head-of-line cells, losers wait.
module mao_arbiter #(
    parameter int N  = 8,
    parameter int L  = 3,
    localparam int DW = $clog2(N),
    localparam int CW = $clog2(L + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_i,
    input  logic [N-1:0]    req_valid_i,
    input  logic [N*DW-1:0] req_dest_i,
    output logic [N-1:0]    grant_o,
    output logic [N*CW-1:0] accept_cnt_o
);
    logic [N-1:0]  match   [N];
    logic [N-1:0]  sel     [N];
    logic [CW-1:0] cnt_nx  [N];
    logic [CW-1:0] cnt_q   [N];
    logic [DW-1:0] ptr     [N];
    logic [DW-1:0] ptr_nx  [N];
    logic [N-1:0]  grant_nx;
    logic [N-1:0]  grant_q;

    for (genvar o = 0; o < N; o++) begin : g_out
        for (genvar i = 0; i < N; i++) begin : g_match
            assign match[o][i] = req_valid_i[i] && (req_dest_i[i*DW +: DW] == DW'(o));
        end

        mao_out_sel #(.N(N), .L(L), .IW(DW), .CW(CW)) u_sel (
            .match_i    (match[o]),
            .ptr_i      (ptr[o]),
            .sel_o      (sel[o]),
            .cnt_o      (cnt_nx[o]),
            .next_ptr_o (ptr_nx[o])
        );

        mao_rr_ptr #(.N(N), .IW(DW)) u_ptr (
            .clk    (clk),
            .rst    (rst),
            .slot_i (slot_i),
            .adv_i  (cnt_nx[o] != '0),
            .next_i (ptr_nx[o]),
            .ptr_o  (ptr[o])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[o] <= '0;
            end else if (slot_i) begin
                cnt_q[o] <= cnt_nx[o];
            end
        end

        assign accept_cnt_o[o*CW +: CW] = cnt_q[o];

        // R2: registered count bounded by L
        a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
            int'(cnt_q[o]) <= L);

        // R3: each output takes min(requests, L)
        a_r3_accept_min: assert property (@(posedge clk) disable iff (rst)
            slot_i |=> int'(cnt_q[o]) ==
                (($countones($past(match[o])) > L) ? L : $countones($past(match[o]))));

        // R5: count agrees with grants to inputs that addressed this output
        a_r5_cnt_grants: assert property (@(posedge clk) disable iff (rst)
            slot_i |=> $countones(grant_q & $past(match[o])) == int'(cnt_q[o]));
    end

    // An input matches exactly one output, so ORing the selections gives one grant at most.
    always_comb begin
        grant_nx = '0;
        for (int o = 0; o < N; o++) begin
            grant_nx = grant_nx | sel[o];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (slot_i) begin
            grant_q <= grant_nx;
        end
    end

    assign grant_o = grant_q;

    // R4: no grant to an input without a valid cell
    a_r4_valid_only: assert property (@(posedge clk) disable iff (rst)
        slot_i |=> (grant_q & ~$past(req_valid_i)) == '0);

    // R6: outputs frozen between slot strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !slot_i |=> ($stable(grant_q) && $stable(accept_cnt_o)));

    // R1: reset clears the grants
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (grant_q == '0));
endmodule

// File: tb/tb_mao_arbiter.sv
`timescale 1ns/1ps
module tb_mao_arbiter;
    localparam int N  = 8;
    localparam int L  = 3;
    localparam int DW = $clog2(N);
    localparam int CW = $clog2(L + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            slot_i = 1'b0;
    logic [N-1:0]    req_valid_i = '0;
    logic [N*DW-1:0] req_dest_i = '0;
    logic [N-1:0]    grant_o;
    logic [N*CW-1:0] accept_cnt_o;

    int checks = 0;
    int errors = 0;
    int mptr [N];
    logic [DW-1:0] dst [N];

    always #2.5 clk = ~clk;

    mao_arbiter #(.N(N), .L(L)) dut (
        .clk(clk), .rst(rst), .slot_i(slot_i),
        .req_valid_i(req_valid_i), .req_dest_i(req_dest_i),
        .grant_o(grant_o), .accept_cnt_o(accept_cnt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Expected grants/counts from R3 and R7, with the bench's own pointers.
    task automatic model(input logic [N-1:0] v, output logic [N-1:0] g,
                         output logic [N*CW-1:0] c, input bit commit);
        g = '0;
        c = '0;
        for (int o = 0; o < N; o++) begin
            int n = 0;
            int last = -1;
            for (int k = 0; k < N; k++) begin
                int idx = (mptr[o] + k) % N;
                if (v[idx] && int'(dst[idx]) == o && n < L) begin
                    g[idx] = 1'b1;
                    n++;
                    last = idx;
                end
            end
            c[o*CW +: CW] = CW'(n);
            if (commit && last >= 0) mptr[o] = (last + 1) % N;
        end
    endtask

    task automatic drive(input logic [N-1:0] v);
        req_valid_i = v;
        for (int i = 0; i < N; i++) req_dest_i[i*DW +: DW] = dst[i];
    endtask

    // One slot: drive at negedge, captured at posedge, sampled at next negedge.
    task automatic run_slot(input logic [N-1:0] v, input string tag);
        logic [N-1:0]    eg;
        logic [N*CW-1:0] ec;
        drive(v);
        slot_i = 1'b1;
        model(v, eg, ec, 1'b1);
        @(negedge clk);
        slot_i = 1'b0;
        chk({tag, " grants"}, 32'(grant_o), 32'(eg));
        chk({tag, " counts"}, 32'(accept_cnt_o), 32'(ec));
        for (int o = 0; o < N; o++)
            if (int'(accept_cnt_o[o*CW +: CW]) > L) chk("R2 count over L", 32'(accept_cnt_o[o*CW +: CW]), 32'(L));
    endtask

    task automatic all_to(input int o);
        for (int i = 0; i < N; i++) dst[i] = DW'(o);
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0]    hold_g;
        logic [N*CW-1:0] hold_c;
        void'($urandom(32'd4242));
        for (int o = 0; o < N; o++) mptr[o] = 0;
        for (int i = 0; i < N; i++) dst[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 reset grants", 32'(grant_o), 32'h0);
        chk("R1 reset counts", 32'(accept_cnt_o), 32'h0);

        // R1 R3 R7: all inputs to output 0, window walks and wraps
        all_to(0);
        run_slot('1, "R1 R3 first window");
        chk("R1 ptr0 start", 32'(grant_o), 32'h07);
        run_slot('1, "R7 second window");
        chk("R7 window 3..5", 32'(grant_o), 32'h38);
        run_slot('1, "R7 R3 wrap window");
        chk("R7 wrap 6,7,0", 32'(grant_o), 32'hC1);
        chk("R3 count L on wrap", 32'(accept_cnt_o[0 +: CW]), 32'(L));

        // R8: output 1 untouched so far, starts at input 0
        all_to(1);
        run_slot('1, "R8 independent pointer");
        chk("R8 output1 from 0", 32'(grant_o), 32'h07);

        // R3: exactly L requesters, all accepted
        all_to(2);
        run_slot(8'b0010_0101, "R3 exactly L");
        chk("R3 exactly L count", 32'(accept_cnt_o[2*CW +: CW]), 32'(L));

        // R4: no valid requests
        run_slot('0, "R4 none valid");
        chk("R4 zero grants", 32'(grant_o), 32'h0);

        // R6: requests without strobe are ignored
        all_to(3);
        run_slot(8'hF0, "R6 setup");
        hold_g = grant_o;
        hold_c = accept_cnt_o;
        all_to(5);
        drive('1);
        @(negedge clk);
        chk("R6 grants held", 32'(grant_o), 32'(hold_g));
        chk("R6 counts held", 32'(accept_cnt_o), 32'(hold_c));
        @(negedge clk);
        chk("R6 grants still held", 32'(grant_o), 32'(hold_g));

        // R5 R3 R7: random traffic, often concentrated on few outputs
        for (int s = 0; s < 400; s++) begin
            logic [N-1:0] v;
            int span = ($urandom_range(0, 1) == 0) ? 1 : N - 1;
            for (int i = 0; i < N; i++) begin
                v[i]   = ($urandom_range(0, 4) != 0);
                dst[i] = DW'($urandom_range(0, span));
            end
            run_slot(v, "R5 R3 random");
            if ($urandom_range(0, 3) == 0) begin
                hold_g = grant_o;
                drive(~v);
                @(negedge clk);
                chk("R6 random hold", 32'(grant_o), 32'(hold_g));
            end
        end

        finish_run();
    end
endmodule